// File: doc/BRIEF.md
# Multi-Cycle Byte Processor Control Core

This block is a small 8-bit processing core with a 16-bit byte address space. Each instruction is one opcode byte. Loads and stores take two more address bytes. The core steps through a fixed chain of states, one state per step, so every instruction class has a known cycle cost:

- copy the program counter into the memory address register and advance the counter;
- strobe a read;
- catch the returned byte in a buffer register;
- move the buffer into the instruction register;
- decode;
- execute.

The core holds six 8-bit working registers, numbered 0 to 5 and written A to F in this brief. An incrementer serves as the arithmetic unit. The only status it keeps is a carry flag and a zero flag. It is meant to sit next to a synchronous byte memory whose read data appears one clock after the read strobe.

Top module: `bytecore_top`

## Requirements
- R1: A synchronous active-low reset clears registers A to F, both flags and the halted output, and loads the program counter with parameter RESET_VEC. The first read after reset is issued to address RESET_VEC.
- R2: Each opcode fetch follows the same steps, one cycle each:
  - the memory address register takes the program counter, and the counter advances by one;
  - mem_rd is high for one cycle with mem_addr equal to that address;
  - the byte is captured into the buffer register;
  - the buffer is copied to the instruction register;
  - decode;
  - execute.
  A single-byte instruction therefore takes 6 cycles.
- R3: Opcodes 8'h3C to 8'h41 increment register (opcode − 8'h3C), so 8'h3C is A and 8'h41 is F. The value wraps from 8'hFF to 8'h00.
- R4: An increment sets flag_carry when the old value was 8'hFF and clears it otherwise. It sets flag_zero when the result is zero. A load leaves flag_carry unchanged.
- R5: Opcode 8'h0r, with r from 0 to 5, loads register r from an absolute address. The address follows as a low byte, then a high byte. flag_zero is set when the loaded byte is zero. A load takes 17 cycles.
- R6: Opcode 8'h1r, with r from 0 to 5, writes register r to an absolute address given in the same operand order. It raises mem_wr for exactly one cycle and leaves the register unchanged. A store takes 15 cycles.
- R7: Opcode 8'hFF raises halted. From then until reset, halted stays high and no read or write strobe is issued.
- R8: Every other opcode is a 6-cycle no-op that fetches no operand bytes and changes no register. This includes 8'h06 to 8'h0F and 8'h16 to 8'h1F.
- R9: mem_rd and mem_wr are never high together, and mem_rd never stays high for two cycles in a row.
- R10: An increment or load of one register leaves the other five unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Byte address from the memory address register |
| mem_rd | output | 1 | Read strobe; data expected one cycle later |
| mem_rdata | input | 8 | Read data from memory |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| flag_carry | output | 1 | Carry out of the last increment |
| flag_zero | output | 1 | Zero result of the last increment or load |
| halted | output | 1 | Core has executed the halt opcode |

## Verification
The bench builds the core with RESET_VEC = 16'hAE00, a non-zero vector whose upper address byte differs from that of the data area. This shows that the program counter starts from the parameter and that the full 16-bit address reaches the bus. The same build lets the data operands (around 16'h0300) be told apart from program bytes in a small memory model. With this setting, whole programs can be timed from reset release to halt, which pins down the cycle cost of every instruction class.

// File: rtl/bytecore_pkg.sv
// Shared widths, controller states and decoded-instruction type for the byte core.
package bytecore_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int NUM_REGS = 6;
    localparam int SEL_W    = $clog2(NUM_REGS);

    localparam logic [DATA_W-1:0] OPC_INC_BASE = 8'h3C;
    localparam logic [DATA_W-1:0] OPC_HALT     = 8'hFF;
    localparam logic [3:0]        NIB_LOAD     = 4'h0;
    localparam logic [3:0]        NIB_STORE    = 4'h1;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_READ,
        ST_CAPTURE,
        ST_XFER,
        ST_DECODE,
        ST_OP_ADR,
        ST_OP_RD,
        ST_OP_CAP,
        ST_OP_MOV,
        ST_DATA_ADR,
        ST_DATA_RD,
        ST_DATA_CAP,
        ST_EXEC,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_INC,
        K_LOAD,
        K_STORE,
        K_HALT
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [SEL_W-1:0] sel;
    } dec_t;

endpackage

// File: rtl/bytecore_decoder.sv
// Instruction decoder.
// Turns the instruction register into an operation kind and a register select.
// Assumes register indices above NUM_REGS-1 are not valid operands; those opcodes decode as no-ops.
module bytecore_decoder
    import bytecore_pkg::*;
(
    input  logic [DATA_W-1:0] ir,
    output dec_t              dec
);

    logic [DATA_W-1:0] inc_off;

    // Offset from the first increment opcode gives the increment target.
    assign inc_off = ir - OPC_INC_BASE;

    // Classify the opcode and pick the register it names.
    always_comb begin
        dec.kind = K_NOP;
        dec.sel  = '0;
        if (ir == OPC_HALT) begin
            dec.kind = K_HALT;
        end else if (inc_off < DATA_W'(NUM_REGS)) begin
            dec.kind = K_INC;
            dec.sel  = inc_off[SEL_W-1:0];
        end else if (ir[7:4] == NIB_LOAD && ir[3:0] < 4'(NUM_REGS)) begin
            dec.kind = K_LOAD;
            dec.sel  = ir[SEL_W-1:0];
        end else if (ir[7:4] == NIB_STORE && ir[3:0] < 4'(NUM_REGS)) begin
            dec.kind = K_STORE;
            dec.sel  = ir[SEL_W-1:0];
        end
    end

endmodule

// File: rtl/bytecore_alu.sv
// Incrementer arithmetic unit.
// Adds one to the operand and reports the carry out and a zero result.
// Purely combinational; the controller decides when the result is kept.
module bytecore_alu
    import bytecore_pkg::*;
(
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              zero
);

    // Widen by one bit so the wrap shows up as a carry.
    assign {carry, result} = {1'b0, opnd} + {{DATA_W{1'b0}}, 1'b1};

    // Flag an all-zero result.
    assign zero = (result == '0);

endmodule

// File: rtl/bytecore_regfile.sv
// Working register file of NUM_REGS byte registers.
// Has one write port and one combinational read port.
// Assumes the write select is in range; an out-of-range select writes nothing and reads zero.
module bytecore_regfile
    import bytecore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Each register clears on reset and loads when it is selected for a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && wsel == SEL_W'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    // Read mux over all registers.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rsel == SEL_W'(i)) rdata = regs[i];
        end
    end

endmodule

// File: rtl/bytecore_ctrl.sv
// Control unit.
// Owns the program counter, memory address register, buffer register, instruction register, operand address and flags.
// Spends one state per step, so each instruction class has a fixed cycle cost.
// Assumes memory read data is valid in the cycle after the read strobe.
module bytecore_ctrl
    import bytecore_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_zero,
    output logic [ADDR_W-1:0] mar,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] br,
    output logic [DATA_W-1:0] ir,
    output state_e            state,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              flag_c,
    output logic              flag_z
);

    logic [ADDR_W-1:0] ea;
    logic              op_hi;

    // Step through the states and update the datapath registers they own.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FETCH;
            pc     <= RESET_VEC;
            mar    <= '0;
            br     <= '0;
            ir     <= '0;
            ea     <= '0;
            op_hi  <= 1'b0;
            flag_c <= 1'b0;
            flag_z <= 1'b0;
        end else begin
            case (state)
                ST_FETCH: begin
                    mar   <= pc;
                    pc    <= pc + 1'b1;
                    state <= ST_READ;
                end
                ST_READ:    state <= ST_CAPTURE;
                ST_CAPTURE: begin
                    br    <= mem_rdata;
                    state <= ST_XFER;
                end
                ST_XFER: begin
                    ir    <= br;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    op_hi <= 1'b0;
                    if (dec.kind == K_LOAD || dec.kind == K_STORE) state <= ST_OP_ADR;
                    else                                           state <= ST_EXEC;
                end
                ST_OP_ADR: begin
                    mar   <= pc;
                    pc    <= pc + 1'b1;
                    state <= ST_OP_RD;
                end
                ST_OP_RD:  state <= ST_OP_CAP;
                ST_OP_CAP: begin
                    br    <= mem_rdata;
                    state <= ST_OP_MOV;
                end
                ST_OP_MOV: begin
                    if (!op_hi) begin
                        ea[7:0] <= br;
                        op_hi   <= 1'b1;
                        state   <= ST_OP_ADR;
                    end else begin
                        ea[ADDR_W-1:8] <= br;
                        state          <= ST_DATA_ADR;
                    end
                end
                ST_DATA_ADR: begin
                    mar   <= ea;
                    state <= (dec.kind == K_LOAD) ? ST_DATA_RD : ST_EXEC;
                end
                ST_DATA_RD:  state <= ST_DATA_CAP;
                ST_DATA_CAP: begin
                    br    <= mem_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (dec.kind == K_INC) begin
                        flag_c <= alu_carry;
                        flag_z <= alu_zero;
                    end else if (dec.kind == K_LOAD) begin
                        flag_z <= (br == '0);
                    end
                    state <= (dec.kind == K_HALT) ? ST_HALT : ST_FETCH;
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_FETCH;
            endcase
        end
    end

    // Memory strobes come straight from the state.
    assign mem_rd = (state == ST_READ) || (state == ST_OP_RD) || (state == ST_DATA_RD);
    assign mem_wr = (state == ST_EXEC) && (dec.kind == K_STORE);

    // Register write-back: the incrementer result or the loaded byte.
    always_comb begin
        reg_we    = 1'b0;
        reg_wdata = br;
        if (state == ST_EXEC) begin
            if (dec.kind == K_INC) begin
                reg_we    = 1'b1;
                reg_wdata = alu_result;
            end else if (dec.kind == K_LOAD) begin
                reg_we    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bytecore_top.sv
// Top of the multi-cycle byte core.
// Wires the control unit, decoder, register file and incrementer to a synchronous byte memory port.
// The instruction's register select drives both the read and the write port of the register file.
module bytecore_top
    import bytecore_pkg::*;
#(
    parameter logic [15:0] RESET_VEC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    input  logic [7:0]  mem_rdata,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    output logic        flag_carry,
    output logic        flag_zero,
    output logic        halted
);

    dec_t              dec;
    state_e            state;
    logic [ADDR_W-1:0] mar;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] br;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] reg_wdata;
    logic              reg_we;
    logic [DATA_W-1:0] alu_result;
    logic              alu_carry;
    logic              alu_zero;

    bytecore_ctrl #(.RESET_VEC(RESET_VEC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rdata  (mem_rdata),
        .dec        (dec),
        .alu_result (alu_result),
        .alu_carry  (alu_carry),
        .alu_zero   (alu_zero),
        .mar        (mar),
        .pc         (pc),
        .br         (br),
        .ir         (ir),
        .state      (state),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .flag_c     (flag_carry),
        .flag_z     (flag_zero)
    );

    bytecore_decoder u_dec (
        .ir  (ir),
        .dec (dec)
    );

    bytecore_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wsel  (dec.sel),
        .wdata (reg_wdata),
        .rsel  (dec.sel),
        .rdata (reg_rdata)
    );

    bytecore_alu u_alu (
        .opnd   (reg_rdata),
        .result (alu_result),
        .carry  (alu_carry),
        .zero   (alu_zero)
    );

    // Memory port and halt status.
    assign mem_addr  = mar;
    assign mem_wdata = reg_rdata;
    assign halted    = (state == ST_HALT);

endmodule

// File: rtl/bytecore_chk.sv
// Assertion checker for bytecore_top, attached by bind.
// Watches the memory strobes, the fetch registers and the halt state.
module bytecore_chk
    import bytecore_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input state_e            state,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] mar,
    input logic [DATA_W-1:0] br,
    input logic [DATA_W-1:0] ir,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted
);

    // R2: the fetch step copies the program counter into the address register and advances it.
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (mar == $past(pc) && pc == $past(pc) + 16'd1));

    // R2: the transfer step copies the buffer register into the instruction register.
    p_ir_from_br_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |=> (ir == $past(br)));

    // R9: the two strobes are never high together.
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: a read strobe lasts one cycle.
    p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R7: once halted, the core stays halted and quiet.
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr));

    // R7: the program counter is frozen while halted.
    p_halt_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

endmodule

bind bytecore_top bytecore_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .pc     (pc),
    .mar    (mar),
    .br     (br),
    .ir     (ir),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
);

// File: tb/test_bytecore_top.sv
// Bench for bytecore_top.
// Drives a small synchronous memory model, walks a vector table of increment cases,
// then runs directed programs for reset, timing, flags, no-ops and halt.
module test_bytecore_top;

    localparam logic [15:0] RV   = 16'hAE00;
    localparam logic [15:0] SRC  = 16'h0300;
    localparam logic [15:0] DST  = 16'h0310;
    localparam int          WDOG = 400_000;

    // Table fields: reg[23:20] init[19:12] expected[11:4] carry[3] zero[2]
    localparam logic [23:0] VEC [6] = '{
        24'h000010, 24'h17F800, 24'h2FEFF0,
        24'h3FF00C, 24'h441420, 24'h5FF00C
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        flag_carry;
    logic        flag_zero;
    logic        halted;

    logic [7:0] mem [0:1023];
    int total = 0;
    int bad   = 0;
    int wr_pulses = 0;
    int overlap   = 0;
    int pc_off    = 0;

    always #2.5 clk = ~clk;

    bytecore_top #(.RESET_VEC(RV)) i_bytecore_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_rdata  (mem_rdata),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .flag_carry (flag_carry),
        .flag_zero  (flag_zero),
        .halted     (halted)
    );

    // Memory model: registered read, write on the strobe; also counts strobe events.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) begin
            mem[mem_addr[9:0]] = mem_wdata;
            wr_pulses++;
        end
        if (mem_rd && mem_wr) overlap++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        pc_off = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        mem[(RV[9:0] + 10'(pc_off))] = b;
        pc_off++;
    endtask

    task automatic emit_mem(input logic [7:0] op, input logic [15:0] a);
        emit(op);
        emit(a[7:0]);
        emit(a[15:8]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs from reset release until halted; returns the cycles taken.
    task automatic run(output int cycles);
        do_reset();
        wr_pulses = 0;
        cycles = 0;
        while (!halted && cycles < 5000) begin
            @(posedge clk);
            #1;
            cycles++;
        end
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int cyc;

        // R1: reset state, then the first read goes to the reset vector.
        clear_mem();
        emit(8'hFF);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 halted in reset", 32'(halted), 0);
        chk("R1 carry in reset", 32'(flag_carry), 0);
        chk("R1 zero in reset", 32'(flag_zero), 0);
        chk("R1 no read in reset", 32'(mem_rd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R2 read strobe after fetch", 32'(mem_rd), 1);
        chk("R1 first address", 32'(mem_addr), 32'(RV));
        @(posedge clk);
        #1;
        chk("R9 read lasts one cycle", 32'(mem_rd), 0);

        // R3 R4 R5 R6: walk the increment table on every register.
        for (int v = 0; v < 6; v++) begin
            logic [3:0] r;
            r = VEC[v][23:20];
            clear_mem();
            mem[SRC[9:0]] = VEC[v][19:12];
            mem[DST[9:0]] = 8'hAA;
            emit_mem({4'h0, r}, SRC);
            emit(8'h3C + {4'h0, r});
            emit_mem({4'h1, r}, DST);
            emit(8'hFF);
            run(cyc);
            chk($sformatf("R3 inc result reg%0d", r), 32'(mem[DST[9:0]]), 32'(VEC[v][11:4]));
            chk($sformatf("R4 carry reg%0d", r), 32'(flag_carry), 32'(VEC[v][3]));
            chk($sformatf("R4 zero reg%0d", r), 32'(flag_zero), 32'(VEC[v][2]));
            chk("R2 R5 R6 program cycles 17+6+15+6", 32'(cyc), 44);
            chk("R6 one write pulse", 32'(wr_pulses), 1);
        end

        // R2 R3: single-byte timing (increment then halt).
        clear_mem();
        emit(8'h3C);
        emit(8'hFF);
        run(cyc);
        chk("R2 inc+halt cycles", 32'(cyc), 12);

        // R5: load timing.
        clear_mem();
        emit_mem(8'h02, SRC);
        emit(8'hFF);
        run(cyc);
        chk("R5 load+halt cycles", 32'(cyc), 23);
        chk("R5 zero after loading 00", 32'(flag_zero), 1);

        // R6: store timing.
        clear_mem();
        emit_mem(8'h10, DST);
        emit(8'hFF);
        run(cyc);
        chk("R6 store+halt cycles", 32'(cyc), 21);

        // R4 R5: a load keeps the carry and refreshes zero.
        clear_mem();
        mem[SRC[9:0]]      = 8'hFF;
        mem[SRC[9:0] + 1]  = 8'h05;
        emit_mem(8'h00, SRC);
        emit(8'h3C);
        emit_mem(8'h01, SRC + 16'd1);
        emit(8'hFF);
        run(cyc);
        chk("R4 carry kept across load", 32'(flag_carry), 1);
        chk("R5 zero cleared by nonzero load", 32'(flag_zero), 0);

        // R10 R1: registers are independent and cleared by reset.
        clear_mem();
        mem[SRC[9:0]] = 8'h55;
        for (int k = 0; k < 4; k++) mem[DST[9:0] + 10'(k)] = 8'hAA;
        emit(8'h3C);
        emit_mem(8'h10, DST);
        emit_mem(8'h12, DST + 16'd1);
        emit_mem(8'h01, SRC);
        emit_mem(8'h11, DST + 16'd2);
        emit_mem(8'h10, DST + 16'd3);
        emit(8'hFF);
        run(cyc);
        chk("R10 A after inc", 32'(mem[DST[9:0]]), 32'h01);
        chk("R1 C cleared by reset", 32'(mem[DST[9:0] + 1]), 32'h00);
        chk("R10 B loaded", 32'(mem[DST[9:0] + 2]), 32'h55);
        chk("R10 A untouched by load of B", 32'(mem[DST[9:0] + 3]), 32'h01);

        // R8: invalid register field and unused opcodes are 6-cycle no-ops.
        clear_mem();
        emit(8'h06);
        emit(8'hFF);
        run(cyc);
        chk("R8 opcode 06 cycles", 32'(cyc), 12);
        clear_mem();
        emit(8'h1F);
        emit(8'hFF);
        run(cyc);
        chk("R8 opcode 1F cycles", 32'(cyc), 12);
        chk("R8 opcode 1F no write", 32'(wr_pulses), 0);
        clear_mem();
        mem[DST[9:0]] = 8'hAA;
        emit(8'h20);
        emit(8'h42);
        emit_mem(8'h10, DST);
        emit(8'hFF);
        run(cyc);
        chk("R8 no-ops leave A", 32'(mem[DST[9:0]]), 32'h00);
        chk("R8 no-ops cost 6 each", 32'(cyc), 6 + 6 + 15 + 6);

        // R7: halted core stays halted and quiet.
        begin
            int strobes;
            strobes = 0;
            for (int k = 0; k < 30; k++) begin
                @(posedge clk);
                #1;
                if (mem_rd || mem_wr || !halted) strobes++;
            end
            chk("R7 quiet while halted", 32'(strobes), 0);
        end

        chk("R9 no read/write overlap", 32'(overlap), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule